// File: doc/BRIEF.md
# Memory-ordering queue with store broadcast and violation detection

This block keeps the in-flight loads and stores of an out-of-order core in a circular queue, oldest at the head. Each slot records whether it is a load or a store, the instruction address (PC) and a sequence number given at allocation. Each slot also has a memory address and a value, plus flags that show which of these are known. Store address and store data arrive separately, by slot index. Once a store has both, the queue broadcasts it one time, with its address, data and sequence number. Every load that is younger than the store and uses the same address reacts to that broadcast. A load that has not yet executed takes the value as its result. A load that has already executed raises an ordering violation, and the block reports the slot and PC of that load.

When a load executes it searches the queue. The block returns the data of the youngest store that is older than the load, has the same address and is complete. That value becomes the load's result; on a miss the result comes from the cache. The core retires slots from the head. When it recovers from a misprediction it flushes every slot younger than a given index, which also moves the tail back. All age comparisons use the position relative to the head, so they stay correct when the queue wraps around.

Top module: `memq_order_guard`

## Requirements
- R1: An accepted allocation fills the slot shown on `alloc_idx` (the tail) and the tail then advances. `full` is high when all DEPTH slots are in use. While `full` is high an allocation is refused and has no effect.
- R2: `retire_valid` frees the head slot and moves the head forward by one. `empty` is high when no slot is in use.
- R3: Address and data writes go to the slot given by their index, and only if that slot is in use. A data write changes a slot only if the slot holds a store.
- R4: A store broadcasts in the cycle after the one in which its second part (address or data) is written. It broadcasts exactly once, with its own address, data and sequence number. If several stores are ready, the oldest goes first and the others follow in later cycles.
- R5: A load reacts to a broadcast only if it is younger than the store, its address is known and the addresses match. If such a load has not executed, at the next edge it takes the broadcast data, and `res_ready` and `res_data` then show that data. A load that is older or has a different address is left unchanged.
- R6: If a load that reacts to a broadcast has already executed, `viol_valid` goes high in the broadcast cycle itself, with that load's index on `viol_idx` and its PC on `viol_pc`.
- R7: When one broadcast hits several executed loads, the oldest of them is reported.
- R8: A search by a load with a known address sets `fwd_hit` in the same cycle when there is a matching store. That store must be older than the load, complete and have the same address. If there are several, the youngest is chosen, and `fwd_idx` and `fwd_data` give its slot and data. Otherwise `fwd_hit` stays low.
- R9: A search marks the load as executed. On a hit, the forwarded data becomes the load's result (`res_ready` high). On a miss, the result stays not ready.
- R10: Age is the slot position minus the head, modulo DEPTH, so ordering stays correct for every head position.
- R11: `flush_valid` with `flush_idx` frees every slot younger than `flush_idx`. The slot at `flush_idx` and all older slots stay. `alloc_idx` becomes `flush_idx`+1, and an allocation in the same cycle is ignored. A flushed store never broadcasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate a slot at the tail |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_pc | input | PCW | Instruction address of the new operation |
| alloc_seq | input | SEQW | Sequence number of the new operation |
| alloc_idx | output | IW | Current tail slot |
| full | output | 1 | All slots in use |
| empty | output | 1 | No slot in use |
| addr_wr_valid | input | 1 | Write a memory address |
| addr_wr_idx | input | IW | Target slot of the address write |
| addr_wr_addr | input | AW | Address value |
| data_wr_valid | input | 1 | Write store data |
| data_wr_idx | input | IW | Target slot of the data write |
| data_wr_data | input | DW | Data value |
| bc_valid | output | 1 | A store broadcast this cycle |
| bc_idx | output | IW | Slot of the broadcasting store |
| bc_addr | output | AW | Address of the broadcast |
| bc_data | output | DW | Data of the broadcast |
| bc_seq | output | SEQW | Sequence number of the broadcasting store |
| srch_valid | input | 1 | Load executes and searches the queue |
| srch_idx | input | IW | Slot of the searching load |
| fwd_hit | output | 1 | A store forwards to the searching load |
| fwd_idx | output | IW | Slot of the forwarding store |
| fwd_data | output | DW | Forwarded data |
| res_idx | input | IW | Slot whose load result is read |
| res_ready | output | 1 | That load has a result from the queue |
| res_data | output | DW | That load's result |
| viol_valid | output | 1 | Ordering violation this cycle |
| viol_idx | output | IW | Oldest violating load |
| viol_pc | output | PCW | PC of that load |
| retire_valid | input | 1 | Free the head slot |
| flush_valid | input | 1 | Free all slots younger than flush_idx |
| flush_idx | input | IW | Youngest slot that survives the flush |

## Verification
Search results (`fwd_hit`, `fwd_idx`, `fwd_data`) and the result read port are combinational, so they are sampled at the falling edge of the same cycle in which the input is driven. A broadcast and any violation it causes appear at the falling edge one cycle after the edge that completed the store. A captured value appears on the result port one edge after the broadcast, and the checks wait exactly that many edges. The sweep covers every head position, every store and load position, and both executed and unexecuted loads, which includes every wrap-around case.

// File: rtl/memq_pkg.sv
// Shared types for the memory-ordering queue.
package memq_pkg;
    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } memq_op_e;
endpackage

// File: rtl/memq_age_pick.sv
// Finds the oldest (or, with YOUNGEST set, the youngest) requesting slot,
// where age is measured from the head. Assumes DEPTH is a power of two.
module memq_age_pick #(
    parameter int DEPTH    = 8,
    parameter bit YOUNGEST = 1'b0,
    localparam int IW      = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] req,
    input  logic [IW-1:0]    head,
    output logic             found,
    output logic [IW-1:0]    idx
);
    generate
        if (YOUNGEST) begin : g_young
            // Walk from oldest to youngest; the last request seen wins.
            always_comb begin
                found = 1'b0;
                idx   = head;
                for (int k = 0; k < DEPTH; k++) begin
                    if (req[head + IW'(k)]) begin
                        found = 1'b1;
                        idx   = head + IW'(k);
                    end
                end
            end
        end else begin : g_old
            // Walk from youngest to oldest; the last request seen wins.
            always_comb begin
                found = 1'b0;
                idx   = head;
                for (int k = DEPTH - 1; k >= 0; k--) begin
                    if (req[head + IW'(k)]) begin
                        found = 1'b1;
                        idx   = head + IW'(k);
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/memq_age_match.sv
// Flags every qualified slot whose address equals ref_addr and which is
// younger (WANT_YOUNGER) or older than the reference slot.
// Assumes DEPTH is a power of two so that ages wrap naturally.
module memq_age_match #(
    parameter int DEPTH        = 8,
    parameter int AW           = 16,
    parameter bit WANT_YOUNGER = 1'b1,
    localparam int IW          = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]         qual,
    input  logic [DEPTH-1:0][AW-1:0] addr,
    input  logic [IW-1:0]            head,
    input  logic [IW-1:0]            ref_idx,
    input  logic [AW-1:0]            ref_addr,
    output logic [DEPTH-1:0]         hit
);
    logic [IW-1:0] ref_age;

    // Age of the reference slot relative to the head.
    assign ref_age = ref_idx - head;

    for (genvar j = 0; j < DEPTH; j++) begin : g_slot
        logic [IW-1:0] age_j;
        logic          order_ok;
        // Age of this slot and its order against the reference.
        assign age_j    = IW'(j) - head;
        assign order_ok = WANT_YOUNGER ? (age_j > ref_age) : (age_j < ref_age);
        assign hit[j]   = qual[j] && (addr[j] == ref_addr) && order_ok;
    end
endmodule

// File: rtl/memq_order_guard.sv
// Circular queue of loads and stores. Complete stores broadcast once, and
// younger matching loads capture the value or report an ordering violation.
// Load searches forward from the youngest older complete store.
// Assumes: DEPTH is a power of two; flush_idx names a slot in use; the core
// retires only complete stores.
module memq_order_guard #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int PCW   = 16,
    parameter int SEQW  = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_valid,
    input  logic            alloc_is_store,
    input  logic [PCW-1:0]  alloc_pc,
    input  logic [SEQW-1:0] alloc_seq,
    output logic [IW-1:0]   alloc_idx,
    output logic            full,
    output logic            empty,
    input  logic            addr_wr_valid,
    input  logic [IW-1:0]   addr_wr_idx,
    input  logic [AW-1:0]   addr_wr_addr,
    input  logic            data_wr_valid,
    input  logic [IW-1:0]   data_wr_idx,
    input  logic [DW-1:0]   data_wr_data,
    output logic            bc_valid,
    output logic [IW-1:0]   bc_idx,
    output logic [AW-1:0]   bc_addr,
    output logic [DW-1:0]   bc_data,
    output logic [SEQW-1:0] bc_seq,
    input  logic            srch_valid,
    input  logic [IW-1:0]   srch_idx,
    output logic            fwd_hit,
    output logic [IW-1:0]   fwd_idx,
    output logic [DW-1:0]   fwd_data,
    input  logic [IW-1:0]   res_idx,
    output logic            res_ready,
    output logic [DW-1:0]   res_data,
    output logic            viol_valid,
    output logic [IW-1:0]   viol_idx,
    output logic [PCW-1:0]  viol_pc,
    input  logic            retire_valid,
    input  logic            flush_valid,
    input  logic [IW-1:0]   flush_idx
);
    import memq_pkg::*;

    localparam int CW = IW + 1;

    // Per-slot state
    logic [DEPTH-1:0]           vld_q, aok_q, dok_q, bcd_q, exe_q, hv_q;
    memq_op_e                   kind_q [DEPTH];
    logic [DEPTH-1:0][PCW-1:0]  pc_q;
    logic [DEPTH-1:0][SEQW-1:0] seq_q;
    logic [DEPTH-1:0][AW-1:0]   addr_q;
    logic [DEPTH-1:0][DW-1:0]   data_q;
    logic [IW-1:0]              head_q;
    logic [CW-1:0]              cnt_q;

    logic [IW-1:0]    tail, fl_age;
    logic             alloc_ok, retire_ok, srch_ok, fwd_found;
    logic [DEPTH-1:0] is_st, st_cplt, ld_known, pend, kill;
    logic [DEPTH-1:0] fwd_mask, bmatch, viol_mask, cap_mask;

    // Queue occupancy and the accepted operations.
    assign tail      = head_q + cnt_q[IW-1:0];
    assign full      = (cnt_q == CW'(DEPTH));
    assign empty     = (cnt_q == '0);
    assign alloc_idx = tail;
    assign alloc_ok  = alloc_valid && !full && !flush_valid;
    assign retire_ok = retire_valid && !empty;
    assign fl_age    = flush_idx - head_q;

    // Per-slot classification and the flush kill mask.
    always_comb begin
        for (int j = 0; j < DEPTH; j++) begin
            is_st[j]    = (kind_q[j] == OP_STORE);
            st_cplt[j]  = vld_q[j] && is_st[j] && aok_q[j] && dok_q[j];
            ld_known[j] = vld_q[j] && !is_st[j] && aok_q[j];
            pend[j]     = st_cplt[j] && !bcd_q[j];
            kill[j]     = flush_valid && ((IW'(j) - head_q) > fl_age);
        end
    end

    // Load search: the youngest older complete store with the same address.
    assign srch_ok = srch_valid && ld_known[srch_idx];

    memq_age_match #(.DEPTH(DEPTH), .AW(AW), .WANT_YOUNGER(1'b0)) u_fwd_match (
        .qual(st_cplt), .addr(addr_q), .head(head_q),
        .ref_idx(srch_idx), .ref_addr(addr_q[srch_idx]), .hit(fwd_mask)
    );

    memq_age_pick #(.DEPTH(DEPTH), .YOUNGEST(1'b1)) u_fwd_pick (
        .req(fwd_mask), .head(head_q), .found(fwd_found), .idx(fwd_idx)
    );

    assign fwd_hit  = srch_ok && fwd_found;
    assign fwd_data = data_q[fwd_idx];

    // Broadcast: the oldest complete store that has not yet broadcast.
    memq_age_pick #(.DEPTH(DEPTH), .YOUNGEST(1'b0)) u_bc_pick (
        .req(pend), .head(head_q), .found(bc_valid), .idx(bc_idx)
    );

    assign bc_addr = addr_q[bc_idx];
    assign bc_data = data_q[bc_idx];
    assign bc_seq  = seq_q[bc_idx];

    // Younger loads with a known, matching address react to the broadcast.
    memq_age_match #(.DEPTH(DEPTH), .AW(AW), .WANT_YOUNGER(1'b1)) u_bc_match (
        .qual(ld_known), .addr(addr_q), .head(head_q),
        .ref_idx(bc_idx), .ref_addr(bc_addr), .hit(bmatch)
    );

    assign viol_mask = bmatch & exe_q & {DEPTH{bc_valid}};
    assign cap_mask  = bmatch & ~exe_q & {DEPTH{bc_valid}};

    memq_age_pick #(.DEPTH(DEPTH), .YOUNGEST(1'b0)) u_viol_pick (
        .req(viol_mask), .head(head_q), .found(viol_valid), .idx(viol_idx)
    );

    assign viol_pc   = pc_q[viol_idx];
    assign res_ready = vld_q[res_idx] && hv_q[res_idx];
    assign res_data  = data_q[res_idx];

    // Head pointer and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (retire_ok) head_q <= head_q + 1'b1;
            if (flush_valid)
                cnt_q <= CW'(fl_age) + CW'(1) - CW'(retire_ok);
            else
                cnt_q <= cnt_q + CW'(alloc_ok) - CW'(retire_ok);
        end
    end

    // Slot contents: allocation, writes, capture, search, retire and flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            aok_q  <= '0;
            dok_q  <= '0;
            bcd_q  <= '0;
            exe_q  <= '0;
            hv_q   <= '0;
            pc_q   <= '0;
            seq_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
            for (int j = 0; j < DEPTH; j++) kind_q[j] <= OP_LOAD;
        end else begin
            for (int j = 0; j < DEPTH; j++) begin
                if (alloc_ok && (tail == IW'(j))) begin
                    vld_q[j]  <= 1'b1;
                    kind_q[j] <= alloc_is_store ? OP_STORE : OP_LOAD;
                    aok_q[j]  <= 1'b0;
                    dok_q[j]  <= 1'b0;
                    bcd_q[j]  <= 1'b0;
                    exe_q[j]  <= 1'b0;
                    hv_q[j]   <= 1'b0;
                    pc_q[j]   <= alloc_pc;
                    seq_q[j]  <= alloc_seq;
                end
                if (addr_wr_valid && vld_q[j] && (addr_wr_idx == IW'(j))) begin
                    addr_q[j] <= addr_wr_addr;
                    aok_q[j]  <= 1'b1;
                end
                if (data_wr_valid && vld_q[j] && is_st[j] && (data_wr_idx == IW'(j))) begin
                    data_q[j] <= data_wr_data;
                    dok_q[j]  <= 1'b1;
                end
                if (bc_valid && (bc_idx == IW'(j))) bcd_q[j] <= 1'b1;
                if (cap_mask[j]) begin
                    data_q[j] <= bc_data;
                    hv_q[j]   <= 1'b1;
                end
                if (srch_ok && (srch_idx == IW'(j))) begin
                    exe_q[j] <= 1'b1;
                    if (fwd_hit) begin
                        data_q[j] <= fwd_data;
                        hv_q[j]   <= 1'b1;
                    end
                end
                if ((retire_ok && (head_q == IW'(j))) || kill[j]) vld_q[j] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/memq_order_guard_chk.sv
// Protocol checks on the memory-ordering queue, attached through bind.
module memq_order_guard_chk #(
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          full,
    input logic          empty,
    input logic [IW:0]   cnt,
    input logic          bc_valid,
    input logic [IW-1:0] bc_idx,
    input logic          viol_valid,
    input logic          srch_valid,
    input logic          fwd_hit
);
    a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= (IW+1)'(DEPTH));

    a_r2_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    a_r4_bcast_once: assert property (@(posedge clk) disable iff (!rst_n)
        bc_valid |=> !(bc_valid && (bc_idx == $past(bc_idx))));

    a_r6_viol_with_bcast: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> bc_valid);

    a_r8_hit_needs_search: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_hit |-> srch_valid);
endmodule

bind memq_order_guard memq_order_guard_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .full(full), .empty(empty), .cnt(cnt_q),
    .bc_valid(bc_valid), .bc_idx(bc_idx), .viol_valid(viol_valid),
    .srch_valid(srch_valid), .fwd_hit(fwd_hit)
);

// File: tb/memq_order_guard_tb.sv
`timescale 1ns/1ps
module memq_order_guard_tb;
    localparam int DEPTH = 8;
    localparam int IW    = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_valid, alloc_is_store, addr_wr_valid, data_wr_valid;
    logic srch_valid, retire_valid, flush_valid;
    logic [15:0] alloc_pc, addr_wr_addr, data_wr_data;
    logic [7:0]  alloc_seq;
    logic [IW-1:0] addr_wr_idx, data_wr_idx, srch_idx, res_idx, flush_idx;
    logic [IW-1:0] alloc_idx, bc_idx, fwd_idx, viol_idx;
    logic full, empty, bc_valid, fwd_hit, res_ready, viol_valid;
    logic [15:0] bc_addr, bc_data, fwd_data, res_data, viol_pc;
    logic [7:0]  bc_seq;

    int nchk = 0, nfail = 0;
    bit done = 0;
    int hd = 0;

    always #2 clk = ~clk;

    memq_order_guard u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store),
        .alloc_pc(alloc_pc), .alloc_seq(alloc_seq), .alloc_idx(alloc_idx),
        .full(full), .empty(empty),
        .addr_wr_valid(addr_wr_valid), .addr_wr_idx(addr_wr_idx), .addr_wr_addr(addr_wr_addr),
        .data_wr_valid(data_wr_valid), .data_wr_idx(data_wr_idx), .data_wr_data(data_wr_data),
        .bc_valid(bc_valid), .bc_idx(bc_idx), .bc_addr(bc_addr), .bc_data(bc_data), .bc_seq(bc_seq),
        .srch_valid(srch_valid), .srch_idx(srch_idx),
        .fwd_hit(fwd_hit), .fwd_idx(fwd_idx), .fwd_data(fwd_data),
        .res_idx(res_idx), .res_ready(res_ready), .res_data(res_data),
        .viol_valid(viol_valid), .viol_idx(viol_idx), .viol_pc(viol_pc),
        .retire_valid(retire_valid), .flush_valid(flush_valid), .flush_idx(flush_idx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        alloc_valid = 0; alloc_is_store = 0; alloc_pc = '0; alloc_seq = '0;
        addr_wr_valid = 0; addr_wr_idx = '0; addr_wr_addr = '0;
        data_wr_valid = 0; data_wr_idx = '0; data_wr_data = '0;
        srch_valid = 0; srch_idx = '0; res_idx = '0;
        retire_valid = 0; flush_valid = 0; flush_idx = '0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    function automatic logic [IW-1:0] ix(input int k);
        return IW'((hd + k) % DEPTH);
    endfunction

    task automatic alloc(input bit st, input int k);
        alloc_valid = 1; alloc_is_store = st;
        alloc_pc = 16'h0100 + 16'(k); alloc_seq = 8'h40 + 8'(k);
        tick(); idle();
    endtask

    task automatic retire(input int n);
        retire_valid = 1;
        repeat (n) tick();
        idle();
        hd = (hd + n) % DEPTH;
    endtask

    task automatic wr_addr(input int k, input logic [15:0] a);
        addr_wr_valid = 1; addr_wr_idx = ix(k); addr_wr_addr = a;
    endtask

    task automatic wr_data(input int k, input logic [15:0] d);
        data_wr_valid = 1; data_wr_idx = ix(k); data_wr_data = d;
    endtask

    // One store and one matching load at ages s and l; the load may have executed.
    task automatic trial(input int s, input int l, input bit ex);
        logic [15:0] a, d;
        bit viol_exp, cap_exp;
        a = 16'h3000 + 16'(hd * 64 + s * 8 + l);
        d = 16'hD000 ^ a ^ {15'd0, ex};
        viol_exp = ex && (s < l);
        cap_exp  = !ex && (s < l);
        for (int k = 0; k < DEPTH; k++) begin
            if (k == 0) check("R1 alloc_idx at tail", 32'(alloc_idx), 32'(hd));
            alloc(k == s, k);
        end
        @(negedge clk);
        check("R1 full after filling", 32'(full), 1);
        if (s == 0 && l == 1 && !ex) begin
            tick(); alloc_valid = 1; tick(); idle();
            @(negedge clk);
            check("R1 refused alloc keeps full", 32'(full), 1);
            check("R1 refused alloc keeps tail", 32'(alloc_idx), 32'(hd));
        end
        tick();
        wr_addr(l, a); tick(); idle();
        if (ex) begin
            srch_valid = 1; srch_idx = ix(l);
            @(negedge clk);
            check("R8 no complete store yet", 32'(fwd_hit), 0);
            tick(); idle();
        end
        wr_addr(s, a); wr_data(s, d); tick(); idle();
        @(negedge clk);
        check("R4 broadcast after completion", 32'(bc_valid), 1);
        check("R4 broadcast idx", 32'(bc_idx), 32'(ix(s)));
        check("R4 broadcast addr", 32'(bc_addr), 32'(a));
        check("R4 broadcast data", 32'(bc_data), 32'(d));
        check("R4 broadcast seq", 32'(bc_seq), 32'(8'h40 + 8'(s)));
        check("R6 R10 violation flag", 32'(viol_valid), 32'(viol_exp));
        if (viol_exp) begin
            check("R6 violation idx", 32'(viol_idx), 32'(ix(l)));
            check("R6 violation pc", 32'(viol_pc), 32'(16'h0100 + 16'(l)));
        end
        tick();
        res_idx = ix(l); srch_valid = 1; srch_idx = ix(l);
        @(negedge clk);
        check("R4 single broadcast", 32'(bc_valid), 0);
        check("R5 R9 load result ready", 32'(res_ready), 32'(cap_exp));
        if (cap_exp) check("R5 captured value", 32'(res_data), 32'(d));
        check("R8 R10 forward hit", 32'(fwd_hit), 32'(s < l));
        if (s < l) begin
            check("R8 forward idx", 32'(fwd_idx), 32'(ix(s)));
            check("R8 forward data", 32'(fwd_data), 32'(d));
        end
        tick(); idle();
        retire(DEPTH);
        @(negedge clk);
        check("R2 empty after retiring all", 32'(empty), 1);
        tick();
    endtask

    // Directed: oldest of several executed loads is reported.
    task automatic t_multi_viol();
        alloc(1, 0); alloc(0, 1); alloc(0, 2); alloc(0, 3);
        wr_addr(1, 16'h5500); tick(); idle();
        wr_addr(2, 16'h5504); tick(); idle();
        wr_addr(3, 16'h5500); tick(); idle();
        srch_valid = 1; srch_idx = ix(3); tick(); idle();
        srch_valid = 1; srch_idx = ix(1); tick(); idle();
        wr_addr(0, 16'h5500); wr_data(0, 16'hBEEF); tick(); idle();
        res_idx = ix(2);
        @(negedge clk);
        check("R7 violation raised", 32'(viol_valid), 1);
        check("R7 oldest violator idx", 32'(viol_idx), 32'(ix(1)));
        check("R7 oldest violator pc", 32'(viol_pc), 32'h0101);
        tick();
        res_idx = ix(2);
        @(negedge clk);
        check("R5 other address not captured", 32'(res_ready), 0);
        tick(); idle();
        retire(4);
    endtask

    // Directed: youngest older store forwards; older matches are overridden.
    task automatic t_youngest_fwd();
        alloc(0, 0); alloc(1, 1); alloc(1, 2); alloc(1, 3); alloc(0, 4);
        wr_addr(0, 16'h7700); tick(); idle();
        wr_addr(4, 16'h7700); tick(); idle();
        wr_addr(1, 16'h7700); wr_data(1, 16'h1111); tick(); idle();
        wr_addr(2, 16'h7700); wr_data(2, 16'h2222); tick(); idle();
        wr_addr(3, 16'h7704); wr_data(3, 16'h3333); tick(); idle();
        tick(); tick();
        res_idx = ix(4);
        @(negedge clk);
        check("R5 last matching broadcast captured", 32'(res_data), 32'h2222);
        check("R5 capture ready", 32'(res_ready), 1);
        res_idx = ix(0); #0.5;
        check("R5 older load ignores broadcast", 32'(res_ready), 0);
        tick();
        srch_valid = 1; srch_idx = ix(4);
        @(negedge clk);
        check("R8 youngest older store hit", 32'(fwd_hit), 1);
        check("R8 youngest older store idx", 32'(fwd_idx), 32'(ix(2)));
        check("R8 youngest older store data", 32'(fwd_data), 32'h2222);
        tick();
        srch_idx = ix(0);
        @(negedge clk);
        check("R8 no older store misses", 32'(fwd_hit), 0);
        tick(); idle();
        res_idx = ix(0);
        @(negedge clk);
        check("R9 miss leaves result not ready", 32'(res_ready), 0);
        tick(); idle();
        retire(5);
    endtask

    // Directed: two stores ready in one cycle broadcast oldest first.
    task automatic t_bcast_order();
        alloc(1, 0); alloc(1, 1);
        wr_data(0, 16'hAAAA); tick(); idle();
        wr_addr(1, 16'h6604); tick(); idle();
        wr_addr(0, 16'h6600); wr_data(1, 16'hBBBB); tick(); idle();
        @(negedge clk);
        check("R4 oldest ready broadcasts first", 32'(bc_idx), 32'(ix(0)));
        check("R4 first broadcast data", 32'(bc_data), 32'hAAAA);
        tick();
        @(negedge clk);
        check("R4 second store follows", 32'(bc_valid), 1);
        check("R4 second broadcast idx", 32'(bc_idx), 32'(ix(1)));
        check("R4 second broadcast data", 32'(bc_data), 32'hBBBB);
        tick();
        @(negedge clk);
        check("R4 no further broadcast", 32'(bc_valid), 0);
        tick();
        retire(2);
    endtask

    // Directed: flush trims the tail and kills a pending store.
    task automatic t_flush();
        alloc(0, 0); alloc(0, 1); alloc(0, 2); alloc(1, 3); alloc(0, 4);
        wr_addr(3, 16'h4400); tick(); idle();
        flush_valid = 1; flush_idx = ix(2); alloc_valid = 1; tick(); idle();
        @(negedge clk);
        check("R11 tail after flush", 32'(alloc_idx), 32'(ix(3)));
        check("R11 not full after flush", 32'(full), 0);
        tick();
        wr_data(3, 16'h9999); tick(); idle();
        @(negedge clk);
        check("R3 R11 flushed store silent", 32'(bc_valid), 0);
        tick();
        for (int k = 3; k < DEPTH; k++) alloc(0, k);
        @(negedge clk);
        check("R11 refill to full", 32'(full), 1);
        tick();
        retire(DEPTH);
        @(negedge clk);
        check("R2 empty after flush test", 32'(empty), 1);
        tick();
    endtask

    initial begin
        idle();
        repeat (3) tick();
        @(negedge clk);
        check("R2 empty at reset", 32'(empty), 1);
        check("R1 not full at reset", 32'(full), 0);
        check("R1 tail at reset", 32'(alloc_idx), 0);
        check("R4 no broadcast at reset", 32'(bc_valid), 0);
        check("R6 no violation at reset", 32'(viol_valid), 0);
        rst_n = 1;
        tick();
        for (int h = 0; h < DEPTH; h++) begin
            if (h > 0) begin
                alloc(0, 0);
                retire(1);
            end
            for (int s = 0; s < DEPTH; s++)
                for (int l = 0; l < DEPTH; l++)
                    if (s != l)
                        for (int e = 0; e < 2; e++) trial(s, l, e[0]);
        end
        t_multi_viol();
        t_youngest_fwd();
        t_bcast_order();
        t_flush();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule